// File: doc/BRIEF.md
# Condition Field Commit Gate

This block sits in the decode stage of a processor pipeline and decides, one instruction at a time, whether an instruction may commit. It reads the four-bit condition field at the top of the instruction word and tests it against the current negative (N), zero (Z), carry (C) and overflow (V) flags. An instruction that fails its test is not dropped. It is marked for squashing, and the pipeline lets it flow on as a no-operation, so the program counter still advances and interrupt and prefetch-abort checks still apply to it.

The all-ones condition value has a different meaning in each architecture generation, so an elaboration parameter picks one of three treatments. In the oldest treatment it means "never execute". In the middle treatment it is reported as unpredictable. In the newest treatment it marks an unconditional extension space, and the instruction is allowed to execute.

All results are registered, giving one cycle of latency. The pipeline around the block, the generation of the flags and any decoding beyond the condition field are outside its scope.

Top module: `cond_gate`

## Requirements
- R1: The condition code is taken from the four most significant bits of the instruction word (bits [31:28] at the default width). The other bits have no effect on any output.
- R2: Codes 0000 to 0111 each test one flag: 0000 passes on Z=1 and 0001 on Z=0; 0010 passes on C=1 and 0011 on C=0; 0100 passes on N=1 and 0101 on N=0; 0110 passes on V=1 and 0111 on V=0.
- R3: Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R4: Code 1010 passes when N equals V. Code 1011 passes when N differs from V.
- R5: Code 1100 passes when Z=0 and N equals V. Code 1101 passes when Z=1 or N differs from V.
- R6: Code 1110 passes for every combination of flags.
- R7: With NV_MODE = 0 (never), code 1111 gives exec_en=0 and squash=1, with uncond_space=0 and cond_unpred=0.
- R8: With NV_MODE = 1 (flagged), code 1111 gives exec_en=0, squash=1 and cond_unpred=1, with uncond_space=0.
- R9: With NV_MODE = 2 (extension, the default), code 1111 gives exec_en=1 and uncond_space=1, with squash=0 and cond_unpred=0.
- R10: For every valid instruction, exactly one of exec_en and squash is 1. A failed condition sets squash so that the instruction advances as a no-operation.
- R11: Outputs show the decision for the instruction presented on the previous rising edge. If instr_valid was 0 at that edge, all four outputs are 0.
- R12: A synchronous, active-high rst clears all four outputs to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction word is present this cycle |
| instr_word | input | INSTR_W (32) | Instruction word; the top four bits hold the condition code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| exec_en | output | 1 | Registered: the instruction commits |
| squash | output | 1 | Registered: the instruction advances as a no-operation |
| uncond_space | output | 1 | Registered: code 1111 taken as unconditional extension space |
| cond_unpred | output | 1 | Registered: code 1111 seen in flagged mode |

## Verification
The bench builds three copies of the block side by side, one for each NV_MODE value (0, 1 and 2), and feeds them the same stimulus. This makes every treatment of the all-ones code observable in one run. The table walk and the reset and idle checks use the default NV_MODE = 2 copy. Each table entry puts the condition code under test in the top nibble and either all zeros or all ones in the lower bits, which shows that the lower bits do not affect the result.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

   // Treatment of the all-ones condition code
   typedef enum logic [1:0] {
      NV_NEVER   = 2'd0,
      NV_FLAGGED = 2'd1,
      NV_EXTEND  = 2'd2
   } nv_mode_e;

   localparam int unsigned COND_W = 4;

   // Registered decision record
   typedef struct packed {
      logic exec;
      logic squash;
      logic uncond;
      logic unpred;
   } gate_out_t;

endpackage

// File: rtl/cond_gate_eval.sv
module cond_gate_eval
   import cond_gate_pkg::*;
(
   input  logic [COND_W-1:0] cond,
   input  logic              fn,
   input  logic              fz,
   input  logic              fc,
   input  logic              fv,
   output logic              pass
);
   logic n_eq_v;
   logic base;

   assign n_eq_v = (fn == fv);

   // Bits [3:1] select the test; bit 0 inverts it (codes 0000 to 1101)
   always_comb begin
      unique case (cond[3:1])
         3'd0:    base = fz;
         3'd1:    base = fc;
         3'd2:    base = fn;
         3'd3:    base = fv;
         3'd4:    base = fc & ~fz;
         3'd5:    base = n_eq_v;
         3'd6:    base = ~fz & n_eq_v;
         default: base = 1'b1;
      endcase
   end

   // 1110 always passes; 1111 is resolved by the all-ones handler
   assign pass = (cond == 4'hE) ? 1'b1 :
                 (cond == 4'hF) ? 1'b0 : (base ^ cond[0]);

endmodule

// File: rtl/cond_gate_nv.sv
module cond_gate_nv
   import cond_gate_pkg::*;
#(
   parameter nv_mode_e NV_MODE = NV_EXTEND
) (
   input  logic is_nv,
   output logic nv_pass,
   output logic nv_uncond,
   output logic nv_unpred
);
   generate
      if (NV_MODE == NV_NEVER) begin : g_never
         assign nv_pass   = 1'b0;
         assign nv_uncond = 1'b0;
         assign nv_unpred = 1'b0;
      end else if (NV_MODE == NV_FLAGGED) begin : g_flagged
         assign nv_pass   = 1'b0;
         assign nv_uncond = 1'b0;
         assign nv_unpred = is_nv;
      end else begin : g_extend
         assign nv_pass   = is_nv;
         assign nv_uncond = is_nv;
         assign nv_unpred = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cond_gate_stage.sv
module cond_gate_stage
   import cond_gate_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      valid,
   input  gate_out_t d,
   output gate_out_t q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (valid) q <= d;
      else            q <= '0;
   end

   AST_ONE_OF_TWO: assert property (@(posedge clk) disable iff (rst)
      valid |=> ($countones({q.exec, q.squash}) == 1)); // R10
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !valid |=> (q == '0)); // R11
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (q == '0)); // R12

endmodule

// File: rtl/cond_gate.sv
module cond_gate
   import cond_gate_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter nv_mode_e    NV_MODE = NV_EXTEND
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               flag_n,
   input  logic               flag_z,
   input  logic               flag_c,
   input  logic               flag_v,
   output logic               exec_en,
   output logic               squash,
   output logic               uncond_space,
   output logic               cond_unpred
);
   localparam int unsigned COND_LSB = INSTR_W - COND_W;

   generate
      if (INSTR_W < 8) begin : g_bad_width
         $error("cond_gate: INSTR_W must be at least 8");
      end
   endgenerate

   logic [COND_W-1:0] cond;
   logic              ev_pass, nv_pass, nv_uncond, nv_unpred, is_nv, pass;
   logic              unused_low;
   gate_out_t         d, q;

   assign cond       = instr_word[INSTR_W-1:COND_LSB];
   assign unused_low = ^instr_word[COND_LSB-1:0];
   assign is_nv      = (cond == 4'hF);

   cond_gate_eval i_eval (
      .cond (cond),
      .fn   (flag_n),
      .fz   (flag_z),
      .fc   (flag_c),
      .fv   (flag_v),
      .pass (ev_pass)
   );

   cond_gate_nv #(.NV_MODE(NV_MODE)) i_nv (
      .is_nv     (is_nv),
      .nv_pass   (nv_pass),
      .nv_uncond (nv_uncond),
      .nv_unpred (nv_unpred)
   );

   assign pass     = is_nv ? nv_pass : ev_pass;
   assign d.exec   = pass;
   assign d.squash = ~pass;
   assign d.uncond = nv_uncond;
   assign d.unpred = nv_unpred;

   cond_gate_stage i_stage (
      .clk   (clk),
      .rst   (rst),
      .valid (instr_valid),
      .d     (d),
      .q     (q)
   );

   assign exec_en      = q.exec;
   assign squash       = q.squash;
   assign uncond_space = q.uncond;
   assign cond_unpred  = q.unpred;

   AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && cond == 4'hE) |=> exec_en); // R6
   AST_EQ_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && cond == 4'h0 && flag_z) |=> exec_en); // R2
   AST_UNCOND_EXEC: assert property (@(posedge clk) disable iff (rst)
      uncond_space |-> (exec_en && !cond_unpred)); // R9
   AST_UNPRED_SQUASH: assert property (@(posedge clk) disable iff (rst)
      cond_unpred |-> (squash && !uncond_space)); // R8

endmodule

// File: tb/test_cond_gate.sv
`timescale 1ns/1ps
module test_cond_gate;
   import cond_gate_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic        fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
   logic        ex2, sq2, un2, up2;
   logic        ex0, sq0, un0, up0;
   logic        ex1, sq1, un1, up1;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   cond_gate i_cond_gate (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
      .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
      .exec_en(ex2), .squash(sq2), .uncond_space(un2), .cond_unpred(up2));
   cond_gate #(.NV_MODE(NV_NEVER)) i_cond_gate_never (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
      .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
      .exec_en(ex0), .squash(sq0), .uncond_space(un0), .cond_unpred(up0));
   cond_gate #(.NV_MODE(NV_FLAGGED)) i_cond_gate_flag (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
      .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
      .exec_en(ex1), .squash(sq1), .uncond_space(un1), .cond_unpred(up1));

   // {cond, N Z C V, expected pass}
   localparam int NV = 28;
   localparam logic [8:0] VEC [NV] = '{
      {4'h0, 4'b0100, 1'b1}, {4'h0, 4'b0000, 1'b0},
      {4'h1, 4'b0000, 1'b1}, {4'h1, 4'b0100, 1'b0},
      {4'h2, 4'b0010, 1'b1}, {4'h3, 4'b0010, 1'b0},
      {4'h3, 4'b1101, 1'b1}, {4'h4, 4'b1000, 1'b1},
      {4'h5, 4'b1000, 1'b0}, {4'h6, 4'b0001, 1'b1},
      {4'h7, 4'b0001, 1'b0}, {4'h8, 4'b0010, 1'b1},
      {4'h8, 4'b0110, 1'b0}, {4'h9, 4'b0110, 1'b1},
      {4'h9, 4'b0010, 1'b0}, {4'h9, 4'b0000, 1'b1},
      {4'hA, 4'b1001, 1'b1}, {4'hA, 4'b1000, 1'b0},
      {4'hB, 4'b0001, 1'b1}, {4'hB, 4'b0000, 1'b0},
      {4'hC, 4'b0000, 1'b1}, {4'hC, 4'b0100, 1'b0},
      {4'hC, 4'b1000, 1'b0}, {4'hD, 4'b0100, 1'b1},
      {4'hD, 4'b0000, 1'b0}, {4'hD, 4'b1000, 1'b1},
      {4'hE, 4'b0000, 1'b1}, {4'hE, 4'b1111, 1'b1}
   };

   task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: {exec,squash,uncond,unpred} = %b, expected %b", req, act, exp);
      end
   endtask

   // Drive on a falling edge; the result is sampled one falling edge later
   task automatic present(input logic v, input logic [31:0] w, input logic [3:0] nzcv);
      @(negedge clk);
      instr_valid = v;
      instr_word  = w;
      {fn, fz, fc, fv} = nzcv;
      @(negedge clk);
   endtask

   initial begin
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R12: reset state, with a valid instruction held at the inputs
      instr_valid = 1'b1;
      instr_word  = 32'hE000_0000;
      repeat (3) @(negedge clk);
      check4("R12 reset", {ex2, sq2, un2, up2}, 4'b0000);
      rst = 1'b0;

      // R1..R6, R10: table walk; lower bits alternate all zeros and all ones
      for (int i = 0; i < NV; i++) begin
         logic [27:0] low;
         logic        p;
         low = (i % 2 == 0) ? 28'h0 : 28'hFFF_FFFF;
         p   = VEC[i][0];
         present(1'b1, {VEC[i][8:5], low}, VEC[i][4:1]);
         check4($sformatf("R1-table-%0d cond %h (R2 R3 R4 R5 R6 R10)", i, VEC[i][8:5]),
                {ex2, sq2, un2, up2}, {p, ~p, 2'b00});
      end

      // R1: the same lower bits and flags, with only the top nibble changed
      present(1'b1, 32'h1FFF_FFFF, 4'b0100);
      check4("R1 top nibble 0001 with Z=1", {ex2, sq2, un2, up2}, 4'b0100);
      present(1'b1, 32'h0FFF_FFFF, 4'b0100);
      check4("R1 top nibble 0000 with Z=1", {ex2, sq2, un2, up2}, 4'b1000);

      // R7, R8, R9: all-ones code under each treatment
      present(1'b1, 32'hF000_1234, 4'b0000);
      check4("R7 never mode", {ex0, sq0, un0, up0}, 4'b0100);
      check4("R8 flagged mode", {ex1, sq1, un1, up1}, 4'b0101);
      check4("R9 extension mode", {ex2, sq2, un2, up2}, 4'b1010);
      present(1'b1, 32'hFFFF_FFFF, 4'b1111);
      check4("R7 never mode, flags set", {ex0, sq0, un0, up0}, 4'b0100);
      check4("R9 extension mode, flags set", {ex2, sq2, un2, up2}, 4'b1010);

      // R11: no valid instruction gives all zeros; results appear one edge later
      present(1'b0, 32'hE000_0000, 4'b0000);
      check4("R11 idle", {ex2, sq2, un2, up2}, 4'b0000);
      check4("R11 idle, flagged copy", {ex1, sq1, un1, up1}, 4'b0000);
      @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = 32'h0000_0000;
      {fn, fz, fc, fv} = 4'b0000;
      #1;
      check4("R11 latency, before the edge", {ex2, sq2, un2, up2}, 4'b0000);
      @(negedge clk);
      check4("R11 latency, after the edge (R10 squash)", {ex2, sq2, un2, up2}, 4'b0100);

      // R12: reset applied mid-stream clears the outputs
      @(negedge clk);
      rst = 1'b1;
      instr_word = 32'hE000_0000;
      @(negedge clk);
      check4("R12 reset mid-stream", {ex2, sq2, un2, up2}, 4'b0000);
      rst = 1'b0;
      @(negedge clk);
      check4("R12 release", {ex2, sq2, un2, up2}, 4'b1000);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule